// File: doc/BRIEF.md
# NAND Device Bus Bridge

This block connects a 32-bit memory-mapped host port to an asynchronous 8-bit NAND flash bus. The host address does more than locate data. One bit drives the address latch enable and another drives the command latch enable. A masked group of bits chooses the second die behind a chip select. The two lowest bits are ignored. Each host word access becomes four byte-wide NAND cycles, low byte first. Each cycle runs through setup, strobe and hold phases whose lengths come from a timing configuration word.

A read is followed by a one-cycle valid pulse carrying the assembled little-endian word. A write that comes directly after a read is delayed by a configurable turnaround gap. A per-chip-select enable vector decides which chip selects run in NAND mode. Requests aimed at any other chip select are dropped. A registered ready flag mirrors the shared, wire-ANDed ready/busy line of the devices. The host waits on a busy flag until every byte cycle of its access has finished.

Top module: `nand_bridge`

## Requirements
- R1: During every byte cycle of an access, `nd_ale` equals host address bit 3 and `nd_cle` equals host address bit 4. Both are low when no access is in progress.
- R2: A host access produces exactly four byte cycles. Byte i carries host data bits [8i+7:8i], with byte 0 first. Host address bits 1:0 have no effect.
- R3: During an access exactly one chip enable is low. For an address with no bit of `DIE_MASK` set (default bit 6), it is `nd_ce_n[cs]`. Otherwise it is `nd_ce_n[cs+4]`. All chip enables are high when idle.
- R4: The timing word holds these fields, each counting clock cycles as value plus one: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4], turnaround [3:2]. Bits [1:0] give the bus size, where 0 means 8-bit. In a write, `nd_we_n` is low for write strobe + 1 cycles per byte, and each byte takes setup+strobe+hold+3 cycles.
- R5: In a read, `nd_re_n` is low for read strobe + 1 cycles per byte. `nd_din` is captured on the last strobe cycle, and the four bytes form `hst_rdata` little-endian. `hst_rvalid` is high for exactly one cycle, the first cycle in which `hst_busy` is low again. It stays low after writes.
- R6: A write that follows a read inserts turnaround + 1 idle cycles before its first setup. No gap is inserted before a read, or before a write that follows a write.
- R7: A request is accepted only while `hst_busy` is low. `hst_busy` goes high in the cycle after acceptance and stays high until the last hold phase ends. `nd_we_n` and `nd_re_n` are never low together.
- R8: A request to a chip select whose bit in `cfg_nand_en` is 0 is dropped. No chip enable or strobe moves, `hst_busy` stays low and no `hst_rvalid` follows.
- R9: `st_ready` equals the value `nd_rdy` had one clock earlier.
- R10: After reset, `hst_busy` and `hst_rvalid` are low, all chip enables and both strobes are high, and both latch enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_req | input | 1 | Host access request, taken when not busy |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_cs | input | CSW (2) | Primary chip select number |
| hst_addr | input | AW (16) | Host byte address (bit 3 ALE, bit 4 CLE, DIE_MASK die) |
| hst_wdata | input | 32 | Write word |
| hst_busy | output | 1 | Access in progress |
| hst_rvalid | output | 1 | One-cycle read-data-valid pulse |
| hst_rdata | output | 32 | Assembled read word |
| cfg_timing | input | 32 | Timing configuration word |
| cfg_nand_en | input | NCS (4) | Per-chip-select NAND-mode enable |
| st_ready | output | 1 | Registered device ready flag |
| nd_ce_n | output | 2*NCS (8) | Chip enables, die 0 in [NCS-1:0], die 1 above |
| nd_ale | output | 1 | Address latch enable |
| nd_cle | output | 1 | Command latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dout | output | 8 | Byte driven to the device |
| nd_doe | output | 1 | Output enable for `nd_dout` |
| nd_din | input | 8 | Byte returned by the device |
| nd_rdy | input | 1 | Wire-ANDed device ready line |

## Verification
A fault in the phase counter shows up directly as a strobe width or a total busy length that differs from the field value plus one. The bench measures both on every access and checks them against the field values. A wrong byte index appears within one access as a misordered byte on `nd_dout`, or as a byte in the wrong lane of `hst_rdata`. A stale read/write history flag is exposed by the busy length of the next write, which gains or loses the turnaround gap. A latched chip select or die error drives the wrong chip enable from the first setup cycle onward.

// File: rtl/nand_bridge.sv
module nand_bridge #(
  parameter int AW = 16,
  parameter int NCS = 4,
  parameter int CSW = $clog2(NCS),
  parameter logic [AW-1:0] DIE_MASK = 'h40,
  parameter int ALE_BIT = 3,
  parameter int CLE_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_req,
  input  logic             hst_we,
  input  logic [CSW-1:0]   hst_cs,
  input  logic [AW-1:0]    hst_addr,
  input  logic [31:0]      hst_wdata,
  output logic             hst_busy,
  output logic             hst_rvalid,
  output logic [31:0]      hst_rdata,
  input  logic [31:0]      cfg_timing,
  input  logic [NCS-1:0]   cfg_nand_en,
  output logic             st_ready,
  output logic [2*NCS-1:0] nd_ce_n,
  output logic             nd_ale,
  output logic             nd_cle,
  output logic             nd_we_n,
  output logic             nd_re_n,
  output logic [7:0]       nd_dout,
  output logic             nd_doe,
  input  logic [7:0]       nd_din,
  input  logic             nd_rdy
);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t             st;
  logic [5:0]      cnt;
  logic [1:0]      bidx;
  logic            we_q, ale_q, cle_q, die_q, last_rd, rvalid_q, rdy_q;
  logic [CSW-1:0]  cs_q;
  logic [31:0]     wd_q, rd_q;

  wire unused_size = ^cfg_timing[1:0];

  wire [5:0] t_su  = we_q ? 6'(cfg_timing[29:26]) : 6'(cfg_timing[16:13]);
  wire [5:0] t_st  = we_q ? cfg_timing[25:20] : cfg_timing[12:7];
  wire [5:0] t_ho  = we_q ? 6'(cfg_timing[19:17]) : 6'(cfg_timing[6:4]);
  wire [5:0] t_ta  = 6'(cfg_timing[3:2]);
  wire [5:0] a_su  = hst_we ? 6'(cfg_timing[29:26]) : 6'(cfg_timing[16:13]);
  wire       accept = (st == S_IDLE) && hst_req && cfg_nand_en[hst_cs];
  wire       active = (st == S_SETUP) || (st == S_STRB) || (st == S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bidx <= '0;
      we_q <= 1'b0;
      ale_q <= 1'b0;
      cle_q <= 1'b0;
      die_q <= 1'b0;
      cs_q <= '0;
      wd_q <= '0;
      rd_q <= '0;
      last_rd <= 1'b0;
      rvalid_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= nd_rdy;
      rvalid_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          we_q  <= hst_we;
          cs_q  <= hst_cs;
          ale_q <= hst_addr[ALE_BIT];
          cle_q <= hst_addr[CLE_BIT];
          die_q <= |(hst_addr & DIE_MASK);
          wd_q  <= hst_wdata;
          bidx  <= '0;
          if (hst_we && last_rd) begin
            st <= S_TURN;
            cnt <= t_ta;
          end else begin
            st <= S_SETUP;
            cnt <= a_su;
          end
        end
        S_TURN:
          if (cnt == 0) begin st <= S_SETUP; cnt <= t_su; end
          else cnt <= cnt - 6'd1;
        S_SETUP:
          if (cnt == 0) begin st <= S_STRB; cnt <= t_st; end
          else cnt <= cnt - 6'd1;
        S_STRB:
          if (cnt == 0) begin
            if (!we_q) rd_q[{bidx, 3'b000} +: 8] <= nd_din;
            st <= S_HOLD;
            cnt <= t_ho;
          end else cnt <= cnt - 6'd1;
        S_HOLD:
          if (cnt != 0) cnt <= cnt - 6'd1;
          else if (bidx == 2'd3) begin
            st <= S_IDLE;
            last_rd <= !we_q;
            rvalid_q <= !we_q;
          end else begin
            bidx <= bidx + 2'd1;
            st <= S_SETUP;
            cnt <= t_su;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < 2 * NCS; i++) begin : g_ce
    localparam logic [CSW-1:0] CSI = CSW'(i % NCS);
    localparam logic DIEI = (i >= NCS);
    assign nd_ce_n[i] = !(active && cs_q == CSI && die_q == DIEI);
  end

  assign nd_ale     = active && ale_q;
  assign nd_cle     = active && cle_q;
  assign nd_we_n    = !(st == S_STRB && we_q);
  assign nd_re_n    = !(st == S_STRB && !we_q);
  assign nd_doe     = active && we_q;
  assign nd_dout    = 8'(wd_q >> {bidx, 3'b000});
  assign hst_busy   = (st != S_IDLE);
  assign hst_rvalid = rvalid_q;
  assign hst_rdata  = rd_q;
  assign st_ready   = rdy_q;

endmodule

module nand_bridge_chk #(
  parameter int NCS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hst_busy,
  input logic             hst_rvalid,
  input logic [2*NCS-1:0] nd_ce_n,
  input logic             nd_we_n,
  input logic             nd_re_n,
  input logic             nd_rdy,
  input logic             st_ready
);

  // R3
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nd_ce_n));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nd_we_n || nd_re_n));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_busy |-> ((&nd_ce_n) && nd_we_n && nd_re_n));

  // R1
  strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nd_we_n || !nd_re_n) |-> !(&nd_ce_n));

  // R5
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rvalid |=> !hst_rvalid);

  // R5
  rvalid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rvalid |-> (!hst_busy && $past(hst_busy)));

  // R9
  ready_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nd_rdy |=> st_ready);

  // R9
  ready_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nd_rdy |=> !st_ready);

endmodule

bind nand_bridge nand_bridge_chk #(.NCS(NCS)) u_chk (.*);

// File: tb/nand_bridge_tb.sv
module nand_bridge_tb;

  typedef struct packed {
    logic        we;
    logic [1:0]  cs;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] tim;
  } vec_t;

  function automatic logic [31:0] tw(int ws, int wst, int wh, int rs, int rst, int rh, int ta);
    return {2'b00, 4'(ws), 6'(wst), 3'(wh), 4'(rs), 6'(rst), 3'(rh), 2'(ta), 2'b00};
  endfunction

  localparam logic [31:0] TA_ = tw(1, 3, 1, 0, 3, 0, 3);
  localparam logic [31:0] TB_ = tw(0, 0, 0, 2, 1, 2, 1);
  localparam logic [31:0] TC_ = tw(15, 63, 7, 15, 63, 7, 0);

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 16'h0010, 32'h44332211, TA_},
    '{1'b1, 2'd2, 16'h000B, 32'hA5C30F96, TB_},
    '{1'b0, 2'd1, 16'h0000, 32'hDEADBEEF, TA_},
    '{1'b1, 2'd3, 16'h0048, 32'h01234567, TA_},
    '{1'b0, 2'd0, 16'h0041, 32'hCAFEF00D, TB_},
    '{1'b0, 2'd2, 16'h0018, 32'h80017FFE, TC_},
    '{1'b1, 2'd1, 16'h0003, 32'h5A5AA5A5, TC_}
  };

  logic        clk = 0, rst_n = 0;
  logic        hst_req = 0, hst_we = 0;
  logic [1:0]  hst_cs = 0;
  logic [15:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0, cfg_timing = 0;
  logic [3:0]  cfg_nand_en = 4'hF;
  logic        nd_rdy = 1;
  logic        hst_busy, hst_rvalid, st_ready, nd_ale, nd_cle, nd_we_n, nd_re_n, nd_doe;
  logic [31:0] hst_rdata;
  logic [7:0]  nd_ce_n, nd_dout, nd_din;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] rd_word = 0;
  int nb = 0, sw = 0, exp_w = 0, wbad = 0, ctlbad = 0;
  logic [7:0] cur_byte;
  logic [31:0] got_word = 0;
  logic exp_ale = 0, exp_cle = 0;
  logic [7:0] exp_ce = 8'hFF;

  always #10 clk = ~clk;

  nand_bridge u_dut (.*);

  assign nd_din = 8'(rd_word >> (8 * (nb % 4)));

  always @(negedge clk) begin
    if (!nd_we_n || !nd_re_n) begin
      sw++;
      cur_byte = nd_we_n ? 8'h00 : nd_dout;
      if (nd_ale !== exp_ale || nd_cle !== exp_cle || nd_ce_n !== exp_ce) ctlbad++;
    end else if (sw != 0) begin
      if (sw != exp_w) wbad++;
      if (nb < 4) got_word[8 * nb +: 8] = cur_byte;
      nb++;
      sw = 0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic prev_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", 32'(hst_busy), 0);
    chk("R10 rvalid", 32'(hst_rvalid), 0);
    chk("R10 ce", 32'(nd_ce_n), 32'hFF);
    chk("R10 strobes", {30'd0, nd_we_n, nd_re_n}, 32'd3);
    chk("R10 latches", {30'd0, nd_ale, nd_cle}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      vec_t e;
      int su, st, ho, ta, bc, exp_bc;
      e = VEC[v];
      su = e.we ? int'(e.tim[29:26]) : int'(e.tim[16:13]);
      st = e.we ? int'(e.tim[25:20]) : int'(e.tim[12:7]);
      ho = e.we ? int'(e.tim[19:17]) : int'(e.tim[6:4]);
      ta = int'(e.tim[3:2]);
      exp_bc = 4 * (su + st + ho + 3) + ((e.we && prev_rd) ? ta + 1 : 0);
      exp_w = st + 1;
      exp_ale = e.addr[3];
      exp_cle = e.addr[4];
      exp_ce = ~(8'h01 << (e.cs + (e.addr[6] ? 4 : 0)));
      rd_word = e.we ? 32'h0 : e.data;
      nb = 0; sw = 0; wbad = 0; ctlbad = 0; got_word = 0;
      cfg_timing = e.tim;
      hst_we = e.we; hst_cs = e.cs; hst_addr = e.addr; hst_wdata = e.data;
      hst_req = 1;
      @(negedge clk);
      hst_req = 0;
      bc = 0;
      while (hst_busy) begin
        bc++;
        @(negedge clk);
      end
      // R4 R6 R7 busy length covers setup/strobe/hold and turnaround
      chk($sformatf("R6 R7 busy cycles v%0d", v), bc, exp_bc);
      // R4 R5 strobe widths
      chk($sformatf("R4 R5 strobe width v%0d", v), wbad, 0);
      // R2 four byte cycles
      chk($sformatf("R2 byte count v%0d", v), nb, 4);
      // R1 R3 latch enables and chip enable during strobe
      chk($sformatf("R1 R3 controls v%0d", v), ctlbad, 0);
      if (e.we) begin
        chk($sformatf("R2 write bytes v%0d", v), got_word, e.data);
        chk($sformatf("R5 no rvalid on write v%0d", v), 32'(hst_rvalid), 0);
      end else begin
        chk($sformatf("R5 rvalid v%0d", v), 32'(hst_rvalid), 1);
        chk($sformatf("R5 rdata v%0d", v), hst_rdata, e.data);
        @(negedge clk);
        chk($sformatf("R5 rvalid single v%0d", v), 32'(hst_rvalid), 0);
      end
      prev_rd = !e.we;
    end

    // R8 disabled chip select is dropped
    cfg_nand_en = 4'b1010;
    nb = 0; sw = 0;
    hst_we = 0; hst_cs = 2'd0; hst_addr = 16'h0008; hst_req = 1;
    @(negedge clk);
    hst_req = 0;
    chk("R8 busy stays low", 32'(hst_busy), 0);
    chk("R8 ce idle", 32'(nd_ce_n), 32'hFF);
    repeat (20) begin
      @(negedge clk);
      if (hst_rvalid || hst_busy || !nd_re_n) nb++;
    end
    chk("R8 no activity", nb, 0);

    // R8 enabled chip select still works next to disabled one
    cfg_timing = TB_;
    hst_we = 1; hst_cs = 2'd1; hst_addr = 16'h0; hst_wdata = 32'h0; hst_req = 1;
    @(negedge clk);
    hst_req = 0;
    chk("R8 enabled cs busy", 32'(hst_busy), 1);
    while (hst_busy) @(negedge clk);

    // R9 ready flag follows the line one clock later
    nd_rdy = 0;
    @(negedge clk);
    chk("R9 ready low", 32'(st_ready), 0);
    nd_rdy = 1;
    @(negedge clk);
    chk("R9 ready high", 32'(st_ready), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule